// File: doc/BRIEF.md
# Circular walk-pipeline feeder with distinguished-result capture

This block is the control shell wrapped around a fixed-latency, fully pipelined iteration datapath used for parallel random-walk searches. Each walk state is a triple holding a point (x, y) and two scalars (c, d). The datapath is a closed ring of `RING_DEPTH` register stages, and each stage carries its own independent walk. The iteration arithmetic is modelled here by a stand-in step function applied where a state leaves the ring.

A slow host loads one staging register. Whenever the slot at the ring exit is idle, the block moves the staged triple into that slot, which then starts circulating. Every state leaving the ring is stepped and then tested. A stepped x-coordinate with at least a programmable number of leading zero bits is appended, as the full triple, to an on-chip first-in first-out buffer. The host drains that buffer whenever it likes. A walk keeps running after it produces a distinguished result. The only way to free a slot is a per-slot kill.

Top module: `walk_ring_shell`

## Requirements
- R1: After reset, `stage_ready` is 1, `buf_count` is 0 and `buf_ovf` is 0. Every ring slot is idle, so no entry is captured until a triple is staged, even with `lz_min` = 0.
- R2: A `stage_wr` pulse while `stage_ready` is 1 captures `stage_x/y/c/d`, and `stage_ready` reads 0 from the next cycle. A `stage_wr` while `stage_ready` is 0 is ignored, and the staged contents are kept.
- R3: Slots are numbered as follows. Slot 0 sits at the ring exit in the first cycle after reset, and the slot number at the exit advances by one each cycle, modulo `RING_DEPTH`. When the exit slot is idle (or is freed that cycle) and a triple is staged, the triple enters the ring at that clock edge and `stage_ready` returns to 1 in the next cycle.
- R4: A triple entering the ring at edge E is stepped as it leaves at edge E+`RING_DEPTH`. The step computes x' = (x rotated left by one) XOR y XOR 0xB5C3, y' = y + x mod 2^16, c' = c + 1 mod 2^12 and d' = d + c mod 2^12. The stepped triple re-enters the ring.
- R5: A stepped triple is captured when the number of leading zero bits of x' (counted from bit 15 downward; a zero x' counts 16) is at least `lz_min`. `lz_min` = 0 captures every stepped triple, and `lz_min` ≥ 17 captures none.
- R6: The buffer returns captured triples in capture order. `buf_x/y/c/d` show the oldest entry whenever `buf_count` > 0. `buf_pop` removes that entry at the next edge. A pop while the buffer is empty has no effect.
- R7: A capture that arrives while `buf_count` equals `BUF_DEPTH` is dropped and sets `buf_ovf`. `buf_ovf` stays at 1 until an `ovf_clr` in a cycle with no drop. A pop in the same cycle does not make room for the capture.
- R8: An active walk whose result is captured keeps circulating with its stepped triple, so it yields a further result on each later pass.
- R9: A `kill_req` with `kill_id` = k frees slot k the next time that slot is at the ring exit, including the same cycle if it is there now. The result of the freed slot is discarded, and the slot may take the staged triple at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_wr | input | 1 | Write the staging register |
| stage_x | input | 16 | Staged point x |
| stage_y | input | 16 | Staged point y |
| stage_c | input | 12 | Staged scalar c |
| stage_d | input | 12 | Staged scalar d |
| stage_ready | output | 1 | Staging register is empty and may be written |
| lz_min | input | 5 | Minimum leading-zero count for capture |
| kill_req | input | 1 | Request to free a slot |
| kill_id | input | 3 | Slot number to free |
| buf_pop | input | 1 | Remove the oldest captured entry |
| buf_x | output | 16 | Oldest entry, x |
| buf_y | output | 16 | Oldest entry, y |
| buf_c | output | 12 | Oldest entry, c |
| buf_d | output | 12 | Oldest entry, d |
| buf_count | output | 4 | Number of buffered entries |
| buf_ovf | output | 1 | Sticky flag: a capture was dropped |
| ovf_clr | input | 1 | Clear the dropped-capture flag |

## Verification
The assertions assume that `kill_id` names an existing slot and that `lz_min` and the staged data are stable across each clock edge. They do not assume that the host respects `stage_ready` or avoids popping an empty buffer: the design must absorb such traffic. The random stimulus therefore writes the staging register regardless of `stage_ready`, pops at random, changes the capture threshold between 0 and values no x can meet, and issues kills to any slot. A cycle-by-cycle reference model in the bench follows each slot's walk, the staged triple and the buffer contents from the requirement text.

// File: rtl/walk_pkg.sv
package walk_pkg;

    localparam int PT_W = 16;
    localparam int SC_W = 12;
    localparam int LZ_W = $clog2(PT_W + 2);
    localparam logic [PT_W-1:0] MIX_K = PT_W'(16'hB5C3);

    typedef struct packed {
        logic [PT_W-1:0] x;
        logic [PT_W-1:0] y;
        logic [SC_W-1:0] c;
        logic [SC_W-1:0] d;
    } walk_t;

    typedef struct packed {
        logic  act;
        walk_t w;
    } slot_t;

    // stand-in for the iteration arithmetic
    function automatic walk_t walk_advance(input walk_t t);
        walk_t n;
        n.x = {t.x[PT_W-2:0], t.x[PT_W-1]} ^ t.y ^ MIX_K;
        n.y = t.y + t.x;
        n.c = t.c + SC_W'(1);
        n.d = t.d + t.c;
        return n;
    endfunction

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [PT_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            seen;
        n    = '0;
        seen = 1'b0;
        for (int i = PT_W - 1; i >= 0; i--) begin
            if (!seen && !v[i]) n = n + LZ_W'(1);
            else                seen = 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/walk_step_unit.sv
module walk_step_unit
    import walk_pkg::*;
(
    input  walk_t           cur,
    input  logic [LZ_W-1:0] lz_min,
    output walk_t           nxt,
    output logic            is_dist
);

    always_comb begin
        nxt     = walk_advance(cur);
        is_dist = (lead_zeros(nxt.x) >= lz_min);
    end

endmodule

// File: rtl/walk_delay_line.sv
module walk_delay_line
    import walk_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t in_slot,
    output slot_t out_slot,
    output logic  first_act
);

    slot_t pipe_d [DEPTH];
    slot_t pipe_q [DEPTH];

    always_comb begin
        pipe_d[0] = in_slot;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= pipe_d[i];
        end
    end

    assign out_slot  = pipe_q[DEPTH-1];
    assign first_act = pipe_q[0].act;

endmodule

// File: rtl/dist_buffer.sv
module dist_buffer
    import walk_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  walk_t                      push_data,
    input  logic                       pop,
    input  logic                       ovf_clr,
    output walk_t                      head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } buf_state_t;

    buf_state_t st_d, st_q;
    walk_t      mem [DEPTH];
    logic       pop_ok, push_ok, drop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop && (st_q.cnt != '0);
        push_ok = push && (st_q.cnt != CNT_W'(DEPTH));
        drop    = push && (st_q.cnt == CNT_W'(DEPTH));
        if (pop_ok)  st_d.rd = bump(st_q.rd);
        if (push_ok) st_d.wr = bump(st_q.wr);
        st_d.cnt = st_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        st_d.ovf = drop | (st_q.ovf & ~ovf_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr] <= push_data;
    end

    assign head  = mem[st_q.rd];
    assign count = st_q.cnt;
    assign ovf   = st_q.ovf;

    // R7: occupancy never passes capacity
    p_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R7: a capture into a full buffer leaves the sticky flag set
    p_drop_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.cnt == CNT_W'(DEPTH)) |=> st_q.ovf);

    // R6: popping an empty buffer changes nothing
    p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !push) |=> (st_q.cnt == '0));

endmodule

// File: rtl/walk_ring_shell.sv
module walk_ring_shell
    import walk_pkg::*;
#(
    parameter int RING_DEPTH = 8,
    parameter int BUF_DEPTH  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            stage_wr,
    input  logic [PT_W-1:0]                 stage_x,
    input  logic [PT_W-1:0]                 stage_y,
    input  logic [SC_W-1:0]                 stage_c,
    input  logic [SC_W-1:0]                 stage_d,
    output logic                            stage_ready,
    input  logic [LZ_W-1:0]                 lz_min,
    input  logic                            kill_req,
    input  logic [$clog2(RING_DEPTH)-1:0]   kill_id,
    input  logic                            buf_pop,
    output logic [PT_W-1:0]                 buf_x,
    output logic [PT_W-1:0]                 buf_y,
    output logic [SC_W-1:0]                 buf_c,
    output logic [SC_W-1:0]                 buf_d,
    output logic [$clog2(BUF_DEPTH+1)-1:0]  buf_count,
    output logic                            buf_ovf,
    input  logic                            ovf_clr
);

    localparam int ID_W = $clog2(RING_DEPTH);

    typedef struct packed {
        logic                  stg_vld;
        walk_t                 stg;
        logic [ID_W-1:0]       ptr;
        logic [RING_DEPTH-1:0] pend;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    slot_t ring_in, ring_out;
    walk_t adv, head;
    logic  adv_dist, kill_hit, kill_now, keep, inject, push, first_act;

    walk_step_unit u_step (
        .cur     (ring_out.w),
        .lz_min  (lz_min),
        .nxt     (adv),
        .is_dist (adv_dist)
    );

    walk_delay_line #(.DEPTH(RING_DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_slot   (ring_in),
        .out_slot  (ring_out),
        .first_act (first_act)
    );

    always_comb begin
        ctl_d    = ctl_q;
        kill_hit = kill_req && (kill_id == ctl_q.ptr);
        kill_now = ctl_q.pend[ctl_q.ptr] | kill_hit;
        keep     = ring_out.act && !kill_now;
        inject   = !keep && ctl_q.stg_vld;
        push     = keep && adv_dist;

        ring_in.act = keep | inject;
        if (keep)        ring_in.w = adv;
        else if (inject) ring_in.w = ctl_q.stg;
        else             ring_in.w = '0;

        if (inject) ctl_d.stg_vld = 1'b0;
        if (stage_wr && !ctl_q.stg_vld) begin
            ctl_d.stg_vld = 1'b1;
            ctl_d.stg.x   = stage_x;
            ctl_d.stg.y   = stage_y;
            ctl_d.stg.c   = stage_c;
            ctl_d.stg.d   = stage_d;
        end

        ctl_d.pend[ctl_q.ptr] = 1'b0;
        if (kill_req && !kill_hit && (32'(kill_id) < RING_DEPTH)) begin
            ctl_d.pend[kill_id] = 1'b1;
        end

        ctl_d.ptr = (ctl_q.ptr == ID_W'(RING_DEPTH - 1)) ? '0 : ctl_q.ptr + ID_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    dist_buffer #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (adv),
        .pop       (buf_pop),
        .ovf_clr   (ovf_clr),
        .head      (head),
        .count     (buf_count),
        .ovf       (buf_ovf)
    );

    assign stage_ready = !ctl_q.stg_vld;
    assign buf_x       = head.x;
    assign buf_y       = head.y;
    assign buf_c       = head.c;
    assign buf_d       = head.d;

    // R2: an accepted write makes the register busy
    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_wr && stage_ready) |=> !stage_ready);

    // R2: a busy staging register keeps its contents until injected
    p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stage_ready && !inject) |=> (!stage_ready && $stable(ctl_q.stg)));

    // R3: injection empties the staging register
    p_inject_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inject |=> stage_ready);

    // R8: a live walk re-enters the ring
    p_walk_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_out.act && !kill_now) |=> first_act);

    // R9: a killed slot with nothing staged re-enters idle
    p_kill_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_now && !ctl_q.stg_vld) |=> !first_act);

endmodule

// File: tb/tb_walk_ring_shell.sv
module tb_walk_ring_shell;

    localparam int D  = 8;
    localparam int BD = 8;

    typedef struct packed {
        logic [15:0] x;
        logic [15:0] y;
        logic [11:0] c;
        logic [11:0] d;
    } btr_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stage_wr = 1'b0;
    logic [15:0] stage_x = '0, stage_y = '0;
    logic [11:0] stage_c = '0, stage_d = '0;
    logic        stage_ready;
    logic [4:0]  lz_min = 5'd17;
    logic        kill_req = 1'b0;
    logic [2:0]  kill_id = '0;
    logic        buf_pop = 1'b0;
    logic [15:0] buf_x, buf_y;
    logic [11:0] buf_c, buf_d;
    logic [3:0]  buf_count;
    logic        buf_ovf;
    logic        ovf_clr = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;

    always #5 clk = ~clk;

    walk_ring_shell #(.RING_DEPTH(D), .BUF_DEPTH(BD)) dut (
        .clk(clk), .rst_n(rst_n), .stage_wr(stage_wr), .stage_x(stage_x),
        .stage_y(stage_y), .stage_c(stage_c), .stage_d(stage_d),
        .stage_ready(stage_ready), .lz_min(lz_min), .kill_req(kill_req),
        .kill_id(kill_id), .buf_pop(buf_pop), .buf_x(buf_x), .buf_y(buf_y),
        .buf_c(buf_c), .buf_d(buf_d), .buf_count(buf_count), .buf_ovf(buf_ovf),
        .ovf_clr(ovf_clr)
    );

    // step rule and leading-zero rule as written in R4 and R5
    function automatic btr_t bstep(input btr_t t);
        btr_t r;
        r.x = ((t.x << 1) | (t.x >> 15)) ^ t.y ^ 16'hB5C3;
        r.y = t.y + t.x;
        r.c = t.c + 12'd1;
        r.d = t.d + t.c;
        return r;
    endfunction

    function automatic int blz(input logic [15:0] v);
        int n = 0;
        while (n < 16 && v[15-n] == 1'b0) n++;
        return n;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model
    bit   m_act [D];
    btr_t m_tr  [D];
    bit   m_pend[D];
    int   m_ptr;
    bit   m_svld;
    btr_t m_stg;
    bit   m_ovf;
    btr_t q[$];

    always @(posedge clk) begin
        int   k, sz;
        bit   kn, keep, old, pushm, pop_ok;
        btr_t r;
        if (!rst_n) begin
            for (int i = 0; i < D; i++) begin m_act[i] = 0; m_pend[i] = 0; m_tr[i] = '0; end
            m_ptr = 0; m_svld = 0; m_stg = '0; m_ovf = 0; q.delete();
        end else begin
            k    = m_ptr;
            old  = m_svld;
            kn   = m_pend[k] || (kill_req && int'(kill_id) == k);
            keep = m_act[k] && !kn;
            r    = bstep(m_tr[k]);
            pushm = keep && (blz(r.x) >= int'(lz_min));
            if (keep) m_tr[k] = r;
            else if (old) begin m_tr[k] = m_stg; m_act[k] = 1; m_svld = 0; end
            else m_act[k] = 0;
            if (stage_wr && !old) begin
                m_svld = 1;
                m_stg = '{x: stage_x, y: stage_y, c: stage_c, d: stage_d};
            end
            m_pend[k] = 0;
            if (kill_req && int'(kill_id) != k) m_pend[kill_id] = 1;
            sz = q.size();
            pop_ok = buf_pop && sz > 0;
            if (pop_ok) void'(q.pop_front());
            if (pushm && sz < BD) q.push_back(r);
            m_ovf = (pushm && sz == BD) || (m_ovf && !ovf_clr);
            m_ptr = (k + 1) % D;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(stage_ready == !m_svld, "R2 ready", stage_ready, !m_svld);
            chk(int'(buf_count) == q.size(), "R6 count", buf_count, q.size());
            chk(buf_ovf == m_ovf, "R7 ovf", buf_ovf, m_ovf);
            if (q.size() > 0)
                chk({buf_x, buf_y, buf_c, buf_d} == q[0], "R6 head",
                    {buf_x, buf_y, buf_c, buf_d}, q[0]);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input btr_t t);
        stage_wr = 1; stage_x = t.x; stage_y = t.y; stage_c = t.c; stage_d = t.d;
        tick(1);
        stage_wr = 0;
    endtask

    task automatic drain();
        while (buf_count != 0) begin buf_pop = 1; tick(1); end
        buf_pop = 0;
    endtask

    task automatic kill_all();
        for (int i = 0; i < D; i++) begin kill_req = 1; kill_id = 3'(i); tick(1); end
        kill_req = 0;
        tick(D + 1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        btr_t t0, e1, e2;
        void'($urandom(32'd20240611));
        tick(4);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk(stage_ready == 1, "R1 ready", stage_ready, 1);
        chk(buf_count == 0, "R1 count", buf_count, 0);
        chk(buf_ovf == 0, "R1 ovf", buf_ovf, 0);
        cmp_on = 1;
        lz_min = 0;
        tick(2 * D);
        chk(buf_count == 0, "R1 idle slots", buf_count, 0);

        // R2/R3/R4/R8: one walk, every result captured
        t0 = '{x: 16'h1234, y: 16'h00F0, c: 12'd5, d: 12'd9};
        e1 = bstep(t0);
        e2 = bstep(e1);
        put(t0);
        chk(stage_ready == 0, "R2 busy after write", stage_ready, 0);
        tick(1);
        chk(stage_ready == 1, "R3 ready after inject", stage_ready, 1);
        tick(D);
        chk(buf_count == 1, "R4 latency", buf_count, 1);
        chk({buf_x, buf_y, buf_c, buf_d} == e1, "R4 step", {buf_x, buf_y, buf_c, buf_d}, e1);
        tick(D);
        lz_min = 17;
        chk(buf_count == 2, "R8 walk continues", buf_count, 2);
        buf_pop = 1; tick(1); buf_pop = 0;
        chk({buf_x, buf_y, buf_c, buf_d} == e2, "R8 second step", {buf_x, buf_y, buf_c, buf_d}, e2);
        drain();

        // R5: threshold 17 captures nothing
        tick(3 * D);
        chk(buf_count == 0, "R5 no capture at 17", buf_count, 0);

        // R9: free every slot, then nothing is produced
        kill_all();
        lz_min = 0;
        tick(2 * D);
        chk(buf_count == 0, "R9 killed walks silent", buf_count, 0);

        // R7: fill and overflow
        for (int i = 0; i < D; i++) begin
            while (!stage_ready) tick(1);
            put('{x: 16'(i * 977), y: 16'(i * 31 + 7), c: 12'(i), d: 12'(3 * i)});
        end
        tick(4 * D);
        chk(buf_ovf == 1, "R7 overflow flag", buf_ovf, 1);
        chk(buf_count == BD, "R7 count capped", buf_count, BD);
        lz_min = 17;
        tick(1);
        ovf_clr = 1; tick(1); ovf_clr = 0;
        chk(buf_ovf == 0, "R7 flag cleared", buf_ovf, 0);
        drain();
        kill_all();

        // random traffic checked against the model
        for (int cyc = 0; cyc < 4000; cyc++) begin
            stage_wr = ($urandom % 4) == 0;
            stage_x  = 16'($urandom); stage_y = 16'($urandom);
            stage_c  = 12'($urandom); stage_d = 12'($urandom);
            buf_pop  = ($urandom % 3) == 0;
            kill_req = ($urandom % 50) == 0;
            kill_id  = 3'($urandom);
            ovf_clr  = ($urandom % 40) == 0;
            if (cyc % 64 == 0) lz_min = (($urandom % 6) == 0) ? 5'd17 : 5'($urandom % 5);
            tick(1);
        end
        stage_wr = 0; buf_pop = 0; kill_req = 0; ovf_clr = 0;
        tick(2);
        finish_run();
    end

endmodule